// File: doc/BRIEF.md
# Token-Passing Channel Readout Controller

This block serves one channel in a chain of readout stages that share a single 12-bit data bus. Each stage holds 256 stored 12-bit conversion results in a register array. A token travels down the chain from stage to stage. A 5-bit channel select input, common to all stages, decides which stage is allowed to use the bus when the token reaches it.

When a stage receives the token and its own channel number is selected, it takes the bus. It then drives its 256 words in index order, one word per read-clock cycle, and raises a valid strobe with each word. After the last word it passes the token on through a one-cycle pulse. A stage whose channel is not selected passes the token on in the next cycle and does not touch the bus. In all other cycles the bus output is released to high impedance.

A token-clear input removes the token at once. It silences the bus and the token output in the same cycle and returns the stage to idle. A simple write port fills the storage array while the stage is idle.

Top module: `tokrd_top`

## Requirements
- R1: After reset, `tok_out`, `rd_oe` and `rd_valid` are all 0, and the stage is idle.
- R2: If `tok_in` is high at a rising clock edge while the stage is idle, `tok_clr` is low and `chan_sel` equals `CHAN_ID`, then from that edge on the stage drives stored words 0, 1, ..., 255 on `rd_bus`, one per cycle, with `rd_oe` high.
- R3: Exactly 256 words are driven. In the cycle right after word 255, `tok_out` is high for exactly one cycle and `rd_oe` is low.
- R4: If an idle stage samples `tok_in` high while `chan_sel` differs from `CHAN_ID`, then `tok_out` is high for exactly the next cycle, and `rd_oe` stays low.
- R5: `rd_valid` is high in exactly the cycles in which a word is driven. Whenever `rd_oe` is low, `rd_bus` is high impedance.
- R6: While `tok_clr` is high, `rd_oe`, `rd_valid` and `tok_out` are low in the same cycle. After a clock edge with `tok_clr` high, the stage is idle: it drives nothing and passes no token until it receives a new one.
- R7: A `tok_in` pulse that arrives during a readout is ignored. The word sequence continues without a restart.
- R8: The word index restarts at 0 for every token the stage accepts, including after a readout was cut short by `tok_clr`.
- R9: `chan_sel` is sampled only when the token is accepted. Changing it during a readout does not affect the readout.
- R10: A write with `wr_en` high stores `wr_data` at index `wr_addr` at the clock edge. A later readout returns the new value at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_clr | input | 1 | Token clear; masks the outputs at once and idles the stage at the edge |
| tok_in | input | 1 | Token from the previous stage |
| chan_sel | input | 5 | Selected channel number |
| wr_en | input | 1 | Storage write enable |
| wr_addr | input | 8 | Storage write index |
| wr_data | input | 12 | Storage write data |
| tok_out | output | 1 | Token to the next stage (one-cycle pulse) |
| rd_valid | output | 1 | Strobe that marks a driven word |
| rd_oe | output | 1 | Bus drive enable |
| rd_bus | output | 12 | Shared data bus; high impedance when not driven |

## Verification
The readout index and the state sit directly behind the bus. If the index starts at the wrong value or skips a step, the wrong word appears on `rd_bus` in the very next cycle. If the state is wrong, the count of driven words changes, or the `tok_out` pulse moves away from the cycle right after word 255, and that is visible within one readout. If the stage stays in the readout state after a clear, or picks up a second token while busy, `rd_oe` or `tok_out` shows it within one cycle. The bench therefore compares every driven word and every hand-off cycle against a model of the stored contents.

// File: rtl/tokrd_pkg.sv
package tokrd_pkg;
    localparam int DATA_W = 12;
    localparam int WORDS  = 256;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_HAND = 2'd2
    } rd_state_e;

    function automatic logic is_last(input int unsigned idx, input int unsigned words);
        return idx == words - 1;
    endfunction
endpackage

// File: rtl/tokrd_store.sv
module tokrd_store
    import tokrd_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = WORDS,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/tokrd_fsm.sv
module tokrd_fsm
    import tokrd_pkg::*;
#(
    parameter int DEPTH = WORDS,
    parameter int AW    = ADDR_W,
    parameter logic [AW-1:0] CHAN_ID = '0,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_clr,
    input  logic          tok_in,
    input  logic [AW-1:0] chan_sel,
    output logic [IW-1:0] idx,
    output logic          reading,
    output logic          handing
);
    rd_state_e     st_q, st_d;
    logic [IW-1:0] idx_q, idx_d;

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            ST_IDLE: begin
                if (tok_in) begin
                    idx_d = '0;
                    st_d  = (chan_sel == CHAN_ID) ? ST_READ : ST_HAND;
                end
            end
            ST_READ: begin
                idx_d = idx_q + 1'b1;
                if (is_last(32'(idx_q), DEPTH)) begin
                    st_d = ST_HAND;
                end
            end
            ST_HAND: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
        if (tok_clr) begin
            st_d  = ST_IDLE;
            idx_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    assign idx     = idx_q;
    assign reading = (st_q == ST_READ);
    assign handing = (st_q == ST_HAND);
endmodule

// File: rtl/tokrd_top.sv
module tokrd_top
    import tokrd_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = WORDS,
    parameter int AW    = ADDR_W,
    parameter logic [AW-1:0] CHAN_ID = 5'd3,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_clr,
    input  logic          tok_in,
    input  logic [AW-1:0] chan_sel,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          tok_out,
    output logic          rd_valid,
    output logic          rd_oe,
    output logic [DW-1:0] rd_bus
);
    logic [IW-1:0] idx;
    logic          reading;
    logic          handing;
    logic          busy;
    logic [DW-1:0] word;

    tokrd_fsm #(.DEPTH(DEPTH), .AW(AW), .CHAN_ID(CHAN_ID)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tok_clr  (tok_clr),
        .tok_in   (tok_in),
        .chan_sel (chan_sel),
        .idx      (idx),
        .reading  (reading),
        .handing  (handing)
    );

    tokrd_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (idx),
        .rd_data (word)
    );

    assign busy     = reading | handing;
    assign rd_oe    = reading & ~tok_clr;
    assign rd_valid = rd_oe;
    assign tok_out  = handing & ~tok_clr;
    assign rd_bus   = rd_oe ? word : {DW{1'bz}};
endmodule

// File: rtl/tokrd_chk.sv
module tokrd_chk #(
    parameter int AW    = 5,
    parameter int DEPTH = 256,
    parameter logic [AW-1:0] CHAN_ID = '0,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          tok_clr,
    input logic          tok_in,
    input logic [AW-1:0] chan_sel,
    input logic          tok_out,
    input logic          rd_oe,
    input logic          busy
);
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !rd_oe) run_cnt <= '0;
        else               run_cnt <= run_cnt + 1'b1;
    end

    // R3
    tok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tok_out |=> !tok_out);

    // R3
    word_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_oe && run_cnt == CW'(DEPTH - 1)) |=> !rd_oe);

    // R4
    fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && tok_in && !tok_clr && chan_sel != CHAN_ID) |=> ((tok_out || tok_clr) && !rd_oe));

    // R6
    clr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        tok_clr |=> !tok_out);

    // R5
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tok_out && rd_oe));
endmodule

bind tokrd_top tokrd_chk #(.AW(AW), .DEPTH(DEPTH), .CHAN_ID(CHAN_ID)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tok_clr  (tok_clr),
    .tok_in   (tok_in),
    .chan_sel (chan_sel),
    .tok_out  (tok_out),
    .rd_oe    (rd_oe),
    .busy     (busy)
);

// File: tb/tokrd_top_bench.sv
module tokrd_top_bench;
    localparam logic [4:0] ID = 5'd3;

    logic        clk = 0;
    logic        rst = 1;
    logic        tok_clr = 0;
    logic        tok_in = 0;
    logic [4:0]  chan_sel = ID;
    logic        wr_en = 0;
    logic [7:0]  wr_addr = 0;
    logic [11:0] wr_data = 0;
    logic        tok_out, rd_valid, rd_oe;
    logic [11:0] rd_bus;

    logic [11:0] model [256];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tokrd_top #(.CHAN_ID(ID)) u_tokrd_top (
        .clk(clk), .rst(rst), .tok_clr(tok_clr), .tok_in(tok_in),
        .chan_sel(chan_sel), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tok_out(tok_out), .rd_valid(rd_valid),
        .rd_oe(rd_oe), .rd_bus(rd_bus)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic give_token(input logic [4:0] ch);
        chan_sel = ch;
        tok_in   = 1;
        @(negedge clk);
        tok_in   = 0;
    endtask

    // R2 R5: at each negedge the next word must be on the bus
    task automatic read_words(input int first, input int n);
        for (int k = 0; k < n; k++) begin
            chk(rd_oe && rd_valid && rd_bus == model[first+k], "R2",
                $sformatf("word %0d", first+k), int'(rd_bus), int'(model[first+k]));
            @(negedge clk);
        end
    endtask

    // R3: hand-off pulse right after word 255
    task automatic check_handoff();
        chk(tok_out && !rd_oe && !rd_valid, "R3", "handoff pulse",
            {tok_out, rd_oe, rd_valid}, 3'b100);
        @(negedge clk);
        chk(!tok_out && !rd_oe, "R3", "pulse one cycle", {tok_out, rd_oe}, 2'b00);
    endtask

    task automatic t_load();
        for (int i = 0; i < 256; i++) begin
            model[i] = 12'((i * 1103 + 517) % 4096);
            wr_en = 1; wr_addr = 8'(i); wr_data = model[i];
            @(negedge clk);
        end
        wr_en = 0;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        chk(!tok_out && !rd_oe && !rd_valid, "R1", "reset outputs",
            {tok_out, rd_oe, rd_valid}, 0);
    endtask

    task automatic t_match();
        give_token(ID);
        read_words(0, 256);
        check_handoff();
    endtask

    task automatic t_mismatch();
        give_token(ID + 5'd7);
        // R4
        chk(tok_out && !rd_oe, "R4", "forward pulse", {tok_out, rd_oe}, 2'b10);
        @(negedge clk);
        chk(!tok_out && !rd_oe, "R4", "forward ends", {tok_out, rd_oe}, 2'b00);
        // R6: a clear during the hand-off kills the pulse at once
        give_token(ID + 5'd1);
        tok_clr = 1;
        #1;
        chk(!tok_out, "R6", "clear masks pulse", int'(tok_out), 0);
        @(negedge clk);
        tok_clr = 0;
        chk(!tok_out && !rd_oe, "R6", "idle after clear", {tok_out, rd_oe}, 0);
        chan_sel = ID;
    endtask

    task automatic t_clear();
        bit seen;
        give_token(ID);
        read_words(0, 10);
        tok_clr = 1;
        #1;
        // R6
        chk(!rd_oe && !rd_valid && !tok_out, "R6", "immediate mask",
            {tok_out, rd_oe, rd_valid}, 0);
        @(negedge clk);
        tok_clr = 0;
        #1;
        chk(!rd_oe && !rd_valid, "R6", "stays idle", {rd_oe, rd_valid}, 0);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            if (tok_out || rd_oe) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R6", "no token after clear", int'(seen), 0);
        // R8: new token restarts at word 0
        give_token(ID);
        read_words(0, 256);
        check_handoff();
    endtask

    task automatic t_retoken();
        give_token(ID);
        read_words(0, 100);
        // R7 R9: token pulse and address change mid-readout
        tok_in   = 1;
        chan_sel = ID + 5'd2;
        read_words(100, 1);
        tok_in = 0;
        read_words(101, 155);
        check_handoff();
        chk(!rd_oe, "R7", "no second readout", int'(rd_oe), 0);
        chan_sel = ID;
    endtask

    task automatic t_rewrite();
        // R10
        model[0] = 12'hABC; model[255] = 12'h123; model[77] = 12'hFFF;
        wr_en = 1; wr_addr = 8'd0;   wr_data = 12'hABC; @(negedge clk);
        wr_addr = 8'd255; wr_data = 12'h123; @(negedge clk);
        wr_addr = 8'd77;  wr_data = 12'hFFF; @(negedge clk);
        wr_en = 0;
        give_token(ID);
        chk(rd_bus == 12'hABC, "R10", "rewritten word 0", int'(rd_bus), 12'hABC);
        read_words(0, 256);
        check_handoff();
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_load();
        t_reset();
        t_match();
        t_mismatch();
        t_clear();
        t_retoken();
        t_rewrite();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule